// File: doc/BRIEF.md
# Level-2 Interrupt Aggregator

This block gathers a vector of level-sensitive interrupt lines into a bank of sticky pending bits. It keeps a per-line disable (mask) bit and drives one combined level request towards a parent interrupt controller. Software reaches the block through a small single-cycle, word-addressed register port. Each of the two state banks, pending and mask, is seen through three words: a read-only status view, a write-one-to-set word and a write-one-to-clear word. Single bits can therefore be changed without a read-modify-write sequence.

A typical handler reads the pending status word and ANDs it with the inverse of the mask status word. For each bit it services, it writes a one to the pending-clear word. Sources are enabled and disabled through the two mask words. Software can raise an interrupt of its own through the pending-set word.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1 and `irq_o` is 0.
- R2: A source line sampled high at a clock edge sets its pending bit. The bit stays set after the line falls.
- R3: Writing word 2 (pending clear) clears each pending bit whose data bit is 1. Bits written as 0 keep their value.
- R4: When a pending-clear write and a high source line hit the same bit at the same edge, the bit stays set.
- R5: Writing word 1 (pending set) sets each pending bit whose data bit is 1.
- R6: Writing word 4 (mask set) sets the named mask bits, which disables those sources. Writing word 5 (mask clear) clears the named mask bits, which enables them. All other mask bits keep their value.
- R7: `irq_o` is 1 exactly when, one edge earlier, some bit was pending with its mask bit at 0. It is the registered OR of pending AND NOT mask.
- R8: Reads of words 1, 2, 4, 5, 6 and 7 return zero. Word 0 reads the pending bits and word 3 reads the mask bits. Writes to words 0, 3, 6 and 7 change no state.
- R9: Writing all ones to mask set and then all ones to pending clear, with all sources low, leaves every source disabled, nothing pending and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| irq_o | output | 1 | Combined level request to the parent controller |

## Verification
Two things can fall on the same pending bit in one cycle: a software acknowledge through the pending-clear word and a source line that is still high. The bench holds one source line high while it writes a one to that bit's clear position. It then reads the pending word back and expects the bit still set. After the line drops, it repeats the write and expects the bit gone. The same ordering is checked by a property that excuses any clear bit whose source was high at that edge.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int NSRC = 32;
  localparam int AW   = 3;

  localparam logic [AW-1:0] WD_PSTAT = 3'd0;
  localparam logic [AW-1:0] WD_PSET  = 3'd1;
  localparam logic [AW-1:0] WD_PCLR  = 3'd2;
  localparam logic [AW-1:0] WD_MSTAT = 3'd3;
  localparam logic [AW-1:0] WD_MSET  = 3'd4;
  localparam logic [AW-1:0] WD_MCLR  = 3'd5;

  // Next value of a set/clear bank; level inputs win over a clear.
  function automatic logic [NSRC-1:0] bank_next(
    input logic [NSRC-1:0] cur,
    input logic [NSRC-1:0] setv,
    input logic [NSRC-1:0] clrv,
    input logic [NSRC-1:0] lvl
  );
    return ((cur & ~clrv) | setv) | lvl;
  endfunction

  function automatic logic any_request(
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] mask
  );
    return |(pend & ~mask);
  endfunction
endpackage

// File: rtl/irqa_bank.sv
module irqa_bank
  import irqa_pkg::*;
#(
  parameter logic [NSRC-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] lvl_i,
  output logic [NSRC-1:0] q_o
);
  logic [NSRC-1:0] q_nxt;

  always_comb q_nxt = bank_next(q_o, set_i, clr_i, lvl_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= q_nxt;
  end
endmodule

// File: rtl/irqa_combine.sv
module irqa_combine
  import irqa_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_request(pend_i, mask_i);
  end
endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl
  import irqa_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_o
);
  logic            wr;
  logic [NSRC-1:0] pset_v, pclr_v, mset_v, mclr_v;
  logic [NSRC-1:0] pend_q, mask_q;
  logic [NSRC-1:0] eff_req;

  assign wr     = bus_en & bus_we;
  assign pset_v = (wr && bus_addr == WD_PSET) ? bus_wdata : '0;
  assign pclr_v = (wr && bus_addr == WD_PCLR) ? bus_wdata : '0;
  assign mset_v = (wr && bus_addr == WD_MSET) ? bus_wdata : '0;
  assign mclr_v = (wr && bus_addr == WD_MCLR) ? bus_wdata : '0;

  irqa_bank #(.RST_VAL('0)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(pset_v), .clr_i(pclr_v),
    .lvl_i(src_i), .q_o(pend_q)
  );

  irqa_bank #(.RST_VAL('1)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_i(mset_v), .clr_i(mclr_v),
    .lvl_i('0), .q_o(mask_q)
  );

  assign eff_req = pend_q & ~mask_q;

  irqa_combine u_comb (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_q), .mask_i(mask_q), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        WD_PSTAT: bus_rdata = pend_q;
        WD_MSTAT: bus_rdata = mask_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk
  import irqa_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic            bus_en,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] bus_rdata,
  input logic            irq_o,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] eff_req
);
  p_src_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(src_i)) == $past(src_i)));

  p_pclr_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == WD_PCLR)
      |=> ((pend_q & $past(bus_wdata) & ~$past(src_i)) == '0));

  p_pset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == WD_PSET)
      |=> ((pend_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_mset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == WD_MSET)
      |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_mclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == WD_MCLR)
      |=> ((mask_q & $past(bus_wdata)) == '0));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && (bus_addr == WD_MSET || bus_addr == WD_MCLR))
      |=> $stable(mask_q));

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (|$past(eff_req))));

  p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr != WD_PSTAT && bus_addr != WD_MSTAT)
      |-> (bus_rdata == '0));
endmodule

bind irq_fanin_ctrl irqa_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .pend_q(pend_q), .mask_q(mask_q), .eff_req(eff_req)
);

// File: tb/tb_irq_fanin_ctrl.sv
module tb_irq_fanin_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  irq_fanin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pexp;
    logic [31:0] mexp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, v); chk("R1 pending after reset", v, 32'h0);
    rd(3'd3, v); chk("R1 mask after reset", v, 32'hFFFF_FFFF);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < 32; i++) begin
      pexp = 32'h1 << i;
      src_i = pexp; tick(); src_i = '0;
      rd(3'd0, v); chk("R2 source latched", v, pexp);
      tick();
      chk("R7 masked source gives no irq", {31'b0, irq_o}, 32'h0);
      wr(3'd5, pexp); tick();
      chk("R7 unmasked pending raises irq", {31'b0, irq_o}, 32'h1);
      wr(3'd2, 32'h0);
      rd(3'd0, v); chk("R3 zero clear bits keep pending", v, pexp);
      wr(3'd2, pexp); tick();
      rd(3'd0, v); chk("R3 clear removes pending", v, 32'h0);
      chk("R7 irq drops after clear", {31'b0, irq_o}, 32'h0);
      wr(3'd4, pexp);
      rd(3'd3, v); chk("R6 remask restores all ones", v, 32'hFFFF_FFFF);
    end

    pexp = 32'hA5A5_0F0F;
    wr(3'd1, pexp);
    rd(3'd0, v); chk("R5 software set", v, pexp);
    tick();
    chk("R7 all masked no irq", {31'b0, irq_o}, 32'h0);

    mexp = 32'hFFFF_FFFF & ~32'h0000_00F0;
    wr(3'd5, 32'h0000_00F0);
    rd(3'd3, v); chk("R6 mask clear others unchanged", v, mexp);
    mexp = mexp | 32'h0000_0010;
    wr(3'd4, 32'h0000_0010);
    rd(3'd3, v); chk("R6 mask set others unchanged", v, mexp);
    tick();
    chk("R7 overlap of pending and enabled", {31'b0, irq_o}, {31'b0, |(pexp & ~mexp)});

    rd(3'd1, v); chk("R8 pend set reads zero", v, 32'h0);
    rd(3'd2, v); chk("R8 pend clear reads zero", v, 32'h0);
    rd(3'd4, v); chk("R8 mask set reads zero", v, 32'h0);
    rd(3'd5, v); chk("R8 mask clear reads zero", v, 32'h0);
    rd(3'd6, v); chk("R8 unmapped 6 reads zero", v, 32'h0);
    rd(3'd7, v); chk("R8 unmapped 7 reads zero", v, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R8 status writes ignored pending", v, pexp);
    rd(3'd3, v); chk("R8 status writes ignored mask", v, mexp);

    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R9 nothing pending", v, 32'h0);
    rd(3'd3, v); chk("R9 all disabled", v, 32'hFFFF_FFFF);
    tick();
    chk("R9 irq low", {31'b0, irq_o}, 32'h0);

    src_i = 32'h0000_0020;
    tick();
    wr(3'd2, 32'h0000_0020);
    rd(3'd0, v); chk("R4 clear loses to active source", v, 32'h0000_0020);
    src_i = '0;
    wr(3'd2, 32'h0000_0020);
    rd(3'd0, v); chk("R4 clear after source drops", v, 32'h0);

    finish_run();
  end
endmodule